// File: doc/BRIEF.md
# Frame Control Register Bank

This block is the software-facing control point of a frame-at-a-time video processing core. A processor reaches it over an AXI4-Lite slave port with 32-bit data and always-OKAY responses. Through it software arms frames, learns when they complete, selects a free-running mode, and programs the picture size and the colour-filter phase. Toward the datapath it issues a one-cycle frame launch pulse and takes back a one-cycle frame-finished pulse. The size and phase that the datapath uses are snapshots, taken when a launch is accepted, so software may edit the live registers at any time without disturbing a frame in flight.

Three small state machines make up the block. The write channel machine has states WR_COLLECT and WR_RESP. In WR_COLLECT it gathers the address and data halves in either order, and it moves to WR_RESP once both are held, committing the write on that transition. It returns to WR_COLLECT when the response is taken. The read channel machine has states RD_IDLE and RD_SEND. It moves from RD_IDLE to RD_SEND when an address is accepted, sampling the register value at that edge, and it returns when the data is taken. The frame sequencer has states SEQ_IDLE, SEQ_LAUNCH and SEQ_RUN. It goes from SEQ_IDLE to SEQ_LAUNCH when a start is pending, latching the shadows on that edge. It always goes from SEQ_LAUNCH to SEQ_RUN after one cycle, which is the launch pulse. It goes from SEQ_RUN back to SEQ_IDLE on the frame-finished pulse.

Register word offsets are as follows. Control is at 0x00. Interrupt global enable is at 0x04, interrupt enables at 0x08, and interrupt status at 0x0C. Active width is at 0x10, active height at 0x18, and colour-filter phase at 0x28. The control bits are: start in bit 0, done in bit 1, idle in bit 2, ready in bit 3, and auto-restart in bit 7.

Top module: `vidctl_regbank`

## Requirements
- R1: After reset the launch pulse, write response and read response are all low. The control register reads 0x0000_0004, which means only idle is set. The snapshot outputs are zero.
- R2: The write address and write data are accepted independently and in either order. A write takes effect only once both halves have arrived. Each write gets exactly one response, with bresp 0 (OKAY), and no response is given before the data arrives.
- R3: Readback follows the field widths. Width (0x10) and height (0x18) return their low DIM_W bits, phase (0x28) returns bits 1:0, global enable (0x04) returns bit 0, and interrupt enables (0x08) return bits 1:0. Status (0x0C) and every unmapped word read 0. rresp is 0.
- R4: Writing control with bit 0 set while idle produces frame_go for exactly one cycle, starting in the cycle after the write response is taken. The start bit reads 1 through that launch cycle and reads 0 afterwards.
- R5: Control bit 3 (ready) reads 1 only in the launch cycle. Control bit 2 (idle) reads 0 from the launch cycle until frame_done arrives, and 1 otherwise.
- R6: frame_done during a running frame sets control bit 1 (done) and it stays set. The first read of control returns it set and clears it. The next read returns it clear.
- R7: Control bit 7 (auto-restart) is stored and read back. While it is 1, each frame_done re-arms start, so a new frame_go follows without any write. While it is 0, the block stays idle after frame_done.
- R8: cur_width, cur_height and cur_phase take the live register values when a launch is accepted, and they are valid during frame_go. Writes made during a frame leave them unchanged until the next launch.
- R9: frame_done while no frame is running is ignored: done stays clear and no launch follows.
- R10: Writes to control bits 1, 2 and 3 are ignored, and writing 0 to bit 0 neither launches nor cancels anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code, always OKAY |
| frame_go | output | 1 | One-cycle frame launch pulse to the datapath |
| frame_done | input | 1 | One-cycle frame finished pulse from the datapath |
| cur_width | output | DIM_W | Width snapshot for the current frame |
| cur_height | output | DIM_W | Height snapshot for the current frame |
| cur_phase | output | 2 | Colour-filter phase snapshot for the current frame |

## Verification
The properties assume that the datapath raises frame_done as a single-cycle pulse, and only after it has seen frame_go. They also assume that a master keeps address and data steady while its valid is waiting. The bench drives every channel from the falling edge and holds each valid until the matching ready has been seen. It also keeps bready and rready high, so responses never stall. The mock datapath pulses frame_done for exactly one cycle. The only frame_done it gives outside a frame is the one deliberate stray pulse that exercises the ignore rule.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

    // byte offsets of the register words
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_GIE    = 'h04;
    localparam int OFF_IER    = 'h08;
    localparam int OFF_ISR    = 'h0C;
    localparam int OFF_WIDTH  = 'h10;
    localparam int OFF_HEIGHT = 'h18;
    localparam int OFF_PHASE  = 'h28;

    // control word bit positions
    localparam int B_START = 0;
    localparam int B_DONE  = 1;
    localparam int B_IDLE  = 2;
    localparam int B_READY = 3;
    localparam int B_AUTO  = 7;

    typedef enum logic {WR_COLLECT, WR_RESP} wr_state_e;
    typedef enum logic {RD_IDLE, RD_SEND} rd_state_e;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_LAUNCH, SEQ_RUN} seq_state_e;

endpackage

// File: rtl/vidctl_axil_wr.sv
module vidctl_axil_wr
    import vidctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    wr_state_e         st_q, st_d;
    logic              aw_have_q, w_have_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= WR_COLLECT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WR_COLLECT: if (aw_have_q && w_have_q) st_d = WR_RESP;
            WR_RESP:    if (bready) st_d = WR_COLLECT;
        endcase
    end

    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        bvalid  = 1'b0;
        wr_en   = 1'b0;
        unique case (st_q)
            WR_COLLECT: begin
                awready = !aw_have_q;
                wready  = !w_have_q;
                wr_en   = aw_have_q && w_have_q;
            end
            WR_RESP: bvalid = 1'b1;
        endcase
    end

    // holding registers for the two halves of a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_have_q <= 1'b0;
            w_have_q  <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_have_q <= 1'b1;
                addr_q    <= awaddr;
            end else if (wr_en) begin
                aw_have_q <= 1'b0;
            end
            if (wvalid && wready) begin
                w_have_q <= 1'b1;
                data_q   <= wdata;
            end else if (wr_en) begin
                w_have_q <= 1'b0;
            end
        end
    end

    assign wr_addr = addr_q;
    assign wr_data = data_q;

endmodule

// File: rtl/vidctl_axil_rd.sv
module vidctl_axil_rd
    import vidctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_take,
    input  logic [DATA_W-1:0] rd_value
);

    rd_state_e         st_q, st_d;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (arvalid) st_d = RD_SEND;
            RD_SEND: if (rready)  st_d = RD_IDLE;
        endcase
    end

    always_comb begin
        arready = 1'b0;
        rvalid  = 1'b0;
        unique case (st_q)
            RD_IDLE: arready = 1'b1;
            RD_SEND: rvalid  = 1'b1;
        endcase
    end

    assign rd_take = arvalid && arready;
    assign rd_addr = araddr;

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_take) rdata_q <= rd_value;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vidctl_frame_seq.sv
module vidctl_frame_seq
    import vidctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic frame_done,
    output logic accept,
    output logic frame_go,
    output logic running,
    output logic fin_ok
);

    seq_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:   if (start_req) st_d = SEQ_LAUNCH;
            SEQ_LAUNCH: st_d = SEQ_RUN;
            SEQ_RUN:    if (frame_done) st_d = SEQ_IDLE;
            default:    st_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        frame_go = 1'b0;
        running  = 1'b1;
        fin_ok   = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                running = 1'b0;
                accept  = start_req;
            end
            SEQ_LAUNCH: frame_go = 1'b1;
            SEQ_RUN:    fin_ok   = frame_done;
            default:    running  = 1'b0;
        endcase
    end

endmodule

// File: rtl/vidctl_regfile.sv
module vidctl_regfile
    import vidctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_take,
    input  logic              accept,
    input  logic              frame_go,
    input  logic              running,
    input  logic              fin_ok,
    output logic [DATA_W-1:0] rd_value,
    output logic              start_req,
    output logic              done_flag,
    output logic [DIM_W-1:0]  cur_width,
    output logic [DIM_W-1:0]  cur_height,
    output logic [1:0]        cur_phase
);

    localparam int IW = ADDR_W - 2;
    localparam logic [IW-1:0] I_CTRL   = IW'(OFF_CTRL   >> 2);
    localparam logic [IW-1:0] I_GIE    = IW'(OFF_GIE    >> 2);
    localparam logic [IW-1:0] I_IER    = IW'(OFF_IER    >> 2);
    localparam logic [IW-1:0] I_ISR    = IW'(OFF_ISR    >> 2);
    localparam logic [IW-1:0] I_WIDTH  = IW'(OFF_WIDTH  >> 2);
    localparam logic [IW-1:0] I_HEIGHT = IW'(OFF_HEIGHT >> 2);
    localparam logic [IW-1:0] I_PHASE  = IW'(OFF_PHASE  >> 2);

    logic [IW-1:0]    wr_idx, rd_idx;
    logic             auto_q, gie_q;
    logic [1:0]       ier_q, phase_q;
    logic [DIM_W-1:0] width_q, height_q;
    logic             wr_ctrl;

    assign wr_idx  = wr_addr[ADDR_W-1:2];
    assign rd_idx  = rd_addr[ADDR_W-1:2];
    assign wr_ctrl = wr_en && (wr_idx == I_CTRL);

    // start: software or auto-restart arms it, the launch cycle clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                          start_req <= 1'b0;
        else if (wr_ctrl && wr_data[B_START]) start_req <= 1'b1;
        else if (fin_ok && auto_q)           start_req <= 1'b1;
        else if (frame_go)                   start_req <= 1'b0;
    end

    // done: sticky set from the datapath, cleared by a control read
    always_ff @(posedge clk) begin
        if (!rst_n)                            done_flag <= 1'b0;
        else if (fin_ok)                       done_flag <= 1'b1;
        else if (rd_take && rd_idx == I_CTRL)  done_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q   <= 1'b0;
            gie_q    <= 1'b0;
            ier_q    <= '0;
            width_q  <= '0;
            height_q <= '0;
            phase_q  <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                I_CTRL:   auto_q   <= wr_data[B_AUTO];
                I_GIE:    gie_q    <= wr_data[0];
                I_IER:    ier_q    <= wr_data[1:0];
                I_WIDTH:  width_q  <= wr_data[DIM_W-1:0];
                I_HEIGHT: height_q <= wr_data[DIM_W-1:0];
                I_PHASE:  phase_q  <= wr_data[1:0];
                default:  ;
            endcase
        end
    end

    // per-frame snapshot taken when the sequencer accepts a start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_width  <= '0;
            cur_height <= '0;
            cur_phase  <= '0;
        end else if (accept) begin
            cur_width  <= width_q;
            cur_height <= height_q;
            cur_phase  <= phase_q;
        end
    end

    always_comb begin
        rd_value = '0;
        case (rd_idx)
            I_CTRL: begin
                rd_value[B_START] = start_req;
                rd_value[B_DONE]  = done_flag;
                rd_value[B_IDLE]  = !running;
                rd_value[B_READY] = frame_go;
                rd_value[B_AUTO]  = auto_q;
            end
            I_GIE:    rd_value[0]   = gie_q;
            I_IER:    rd_value[1:0] = ier_q;
            I_ISR:    rd_value      = '0;
            I_WIDTH:  rd_value      = DATA_W'(width_q);
            I_HEIGHT: rd_value      = DATA_W'(height_q);
            I_PHASE:  rd_value[1:0] = phase_q;
            default:  rd_value      = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{wr_data[DATA_W-1:DIM_W], wr_addr[1:0], rd_addr[1:0]};

endmodule

// File: rtl/vidctl_regbank.sv
module vidctl_regbank
    import vidctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int DIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              frame_go,
    input  logic              frame_done,
    output logic [DIM_W-1:0]  cur_width,
    output logic [DIM_W-1:0]  cur_height,
    output logic [1:0]        cur_phase
);

    logic              wr_en, rd_take, accept, seq_running, fin_ok;
    logic              start_req, done_flag;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_value;

    assign bresp = 2'b00;
    assign rresp = 2'b00;

    vidctl_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .bvalid(bvalid), .bready(bready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    vidctl_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata),
        .rd_addr(rd_addr), .rd_take(rd_take), .rd_value(rd_value)
    );

    vidctl_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .frame_done(frame_done),
        .accept(accept), .frame_go(frame_go),
        .running(seq_running), .fin_ok(fin_ok)
    );

    vidctl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_take(rd_take),
        .accept(accept), .frame_go(frame_go), .running(seq_running), .fin_ok(fin_ok),
        .rd_value(rd_value), .start_req(start_req), .done_flag(done_flag),
        .cur_width(cur_width), .cur_height(cur_height), .cur_phase(cur_phase)
    );

endmodule

// File: rtl/vidctl_regbank_chk.sv
module vidctl_regbank_chk #(
    parameter int DATA_W = 32,
    parameter int DIM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_go,
    input logic              frame_done,
    input logic              bvalid,
    input logic              bready,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [DIM_W-1:0]  cur_width,
    input logic [DIM_W-1:0]  cur_height,
    input logic [1:0]        cur_phase,
    input logic              seq_running,
    input logic              done_flag
);

    // R2: a pending write response waits for bready
    p_bresp_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

    // R3: read data stays steady while rvalid waits
    p_rdata_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

    // R4: the launch pulse lasts a single cycle
    p_go_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |=> !frame_go);

    // R5: launch cycle is never an idle cycle
    p_go_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |-> seq_running);

    // R6: finishing a running frame leaves done set
    p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && seq_running && !frame_go |=> done_flag);

    // R8: snapshots change only into a launch cycle
    p_snap_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_go |-> $stable(cur_width) && $stable(cur_height) && $stable(cur_phase));

    // R9: a stray finish while idle does not raise done
    p_stray_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !seq_running && !done_flag |=> !done_flag);

endmodule

bind vidctl_regbank vidctl_regbank_chk #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .frame_done(frame_done),
    .bvalid(bvalid), .bready(bready), .rvalid(rvalid), .rready(rready), .rdata(rdata),
    .cur_width(cur_width), .cur_height(cur_height), .cur_phase(cur_phase),
    .seq_running(seq_running), .done_flag(done_flag)
);

// File: tb/tb_vidctl_regbank.sv
module tb_vidctl_regbank;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int DIM_W  = 16;
    localparam int NV     = 9;

    // register table: address, written value, expected readback
    localparam logic [7:0]  VA [NV] = '{8'h10, 8'h18, 8'h28, 8'h04, 8'h08, 8'h0C, 8'h14, 8'h24, 8'h40};
    localparam logic [31:0] VW [NV] = '{32'h1234_0780, 32'hABCD_0438, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5555_5555, 32'hFFFF_FFFF};
    localparam logic [31:0] VE [NV] = '{32'h0000_0780, 32'h0000_0438, 32'h3, 32'h1,
                                        32'h3, 32'h0, 32'h0, 32'h0, 32'h0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, arvalid = 1'b0, rready = 1'b1;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic awready, wready, bvalid, arready, rvalid, frame_go;
    logic frame_done = 1'b0;
    logic [1:0] bresp, rresp, cur_phase;
    logic [DATA_W-1:0] rdata;
    logic [DIM_W-1:0] cur_width, cur_height;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    vidctl_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp),
        .frame_go(frame_go), .frame_done(frame_done),
        .cur_width(cur_width), .cur_height(cur_height), .cur_phase(cur_phase)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic send_aw(input logic [7:0] a);
        awvalid = 1'b1;
        awaddr  = a;
        while (!awready) @(negedge clk);
        @(negedge clk);
        awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] d);
        wvalid = 1'b1;
        wdata  = d;
        while (!wready) @(negedge clk);
        @(negedge clk);
        wvalid = 1'b0;
    endtask

    task automatic wait_b();
        while (!bvalid) @(negedge clk);
        check("R2 bresp", {30'b0, bresp}, 32'h0);
        @(negedge clk);
    endtask

    task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input int mode);
        if (mode == 1) begin
            send_aw(a);
            send_w(d);
        end else if (mode == 2) begin
            send_w(d);
            send_aw(a);
        end else begin
            fork
                send_aw(a);
                send_w(d);
            join
        end
        wait_b();
    endtask

    task automatic axi_read(input logic [7:0] a, output logic [31:0] d);
        arvalid = 1'b1;
        araddr  = a;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        d = rdata;
        check("R3 rresp", {30'b0, rresp}, 32'h0);
        @(negedge clk);
    endtask

    task automatic pulse_done();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic print_summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (R1..) actual=timeout expected=finished");
        print_summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 frame_go", {31'b0, frame_go}, 32'h0);
        check("R1 bvalid", {31'b0, bvalid}, 32'h0);
        check("R1 rvalid", {31'b0, rvalid}, 32'h0);
        check("R1 cur_width", {16'b0, cur_width}, 32'h0);
        axi_read(8'h00, v);
        check("R1 control", v, 32'h0000_0004);
        axi_read(8'h10, v);
        check("R1 width", v, 32'h0);

        // R3: table of register writes and readbacks, rotating channel order
        for (int i = 0; i < NV; i++) begin
            axi_write(VA[i], VW[i], i % 3);
            axi_read(VA[i], v);
            check("R3 readback", v, VE[i]);
        end
        check("R3 no launch from table", {31'b0, frame_go}, 32'h0);

        // R2: address first, data held back; no effect until data arrives
        axi_write(8'h10, 32'h0000_0111, 0);
        send_aw(8'h10);
        repeat (3) @(negedge clk);
        check("R2 no bvalid before data", {31'b0, bvalid}, 32'h0);
        axi_read(8'h10, v);
        check("R2 old value kept", v, 32'h0000_0111);
        send_w(32'h0000_0222);
        wait_b();
        axi_read(8'h10, v);
        check("R2 value after both halves", v, 32'h0000_0222);
        // R2: data first
        send_w(32'h0000_0333);
        repeat (2) @(negedge clk);
        check("R2 no bvalid before address", {31'b0, bvalid}, 32'h0);
        send_aw(8'h10);
        wait_b();
        axi_read(8'h10, v);
        check("R2 data-first write", v, 32'h0000_0333);

        // R10: read-only bits and a zero start are ignored
        axi_write(8'h00, 32'h0000_000E, 0);
        check("R10 no launch", {31'b0, frame_go}, 32'h0);
        axi_read(8'h00, v);
        check("R10 control unchanged", v, 32'h0000_0004);

        // R4/R5/R8: start a frame with a known size and phase
        axi_write(8'h10, 32'd640, 0);
        axi_write(8'h18, 32'd480, 0);
        axi_write(8'h28, 32'd1, 0);
        axi_write(8'h00, 32'h0000_0001, 0);
        check("R4 frame_go after write", {31'b0, frame_go}, 32'h1);
        check("R8 width snapshot", {16'b0, cur_width}, 32'd640);
        check("R8 height snapshot", {16'b0, cur_height}, 32'd480);
        check("R8 phase snapshot", {30'b0, cur_phase}, 32'd1);
        axi_read(8'h00, v);
        check("R5 ready in launch cycle", v, 32'h0000_0009);
        check("R4 single pulse", {31'b0, frame_go}, 32'h0);
        axi_read(8'h00, v);
        check("R4 start cleared, R5 busy", v, 32'h0000_0000);

        // R8: edits during the frame leave the snapshot alone
        axi_write(8'h10, 32'd1280, 1);
        axi_write(8'h28, 32'd2, 2);
        check("R8 width held", {16'b0, cur_width}, 32'd640);
        check("R8 phase held", {30'b0, cur_phase}, 32'd1);

        // R6: done set by finish, cleared by read
        pulse_done();
        axi_read(8'h00, v);
        check("R6 done and idle", v, 32'h0000_0006);
        axi_read(8'h00, v);
        check("R6 done cleared by read", v, 32'h0000_0004);

        // R9: stray finish while idle
        pulse_done();
        repeat (3) @(negedge clk);
        check("R9 no launch", {31'b0, frame_go}, 32'h0);
        axi_read(8'h00, v);
        check("R9 done stays clear", v, 32'h0000_0004);

        // R8: next frame picks up the new values
        axi_write(8'h00, 32'h0000_0001, 0);
        check("R8 second launch", {31'b0, frame_go}, 32'h1);
        check("R8 new width", {16'b0, cur_width}, 32'd1280);
        check("R8 new phase", {30'b0, cur_phase}, 32'd2);
        @(negedge clk);
        pulse_done();
        axi_read(8'h00, v);
        check("R6 second done", v, 32'h0000_0006);

        // R7: auto-restart relaunches without a write
        axi_write(8'h00, 32'h0000_0081, 0);
        check("R7 first launch", {31'b0, frame_go}, 32'h1);
        @(negedge clk);
        pulse_done();
        seen = 0;
        for (int k = 0; k < 10 && seen == 0; k++) begin
            if (frame_go) seen = 1;
            else @(negedge clk);
        end
        check("R7 relaunch without write", seen, 1);
        @(negedge clk);
        axi_read(8'h00, v);
        check("R7 auto bit with done", v, 32'h0000_0082);
        axi_write(8'h00, 32'h0000_0000, 0);
        pulse_done();
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            if (frame_go) seen = 1;
            @(negedge clk);
        end
        check("R7 no relaunch when off", seen, 0);
        axi_read(8'h00, v);
        check("R7 idle after last frame", v, 32'h0000_0006);

        print_summary();
        $finish;
    end

endmodule